// File: doc/BRIEF.md
# Feature Control Register Write Filter

This block owns the 32-bit feature control register of a paging processor and screens every software write to it. Four capability inputs, together with a fixed set of always-writable low bits, form an allow mask at run time. A write that would set any bit outside the mask is refused: the register keeps its value and a fault pulse is raised. A write that passes is committed. When the write changes any bit that affects address translation, the block pulses a TLB flush request. In a narrower case it also pulses a request to reload and check the page-directory-pointer entries. The block does not carry out the flush or the reload.

A small state machine records what the last clock edge did with the write strobe. S_IDLE means no write was seen. S_TOOK means a write was committed. S_REFUSED means a write was rejected. The transitions are taken on every edge: no strobe goes to S_IDLE, a strobe with legal data goes to S_TOOK, and a strobe with illegal data goes to S_REFUSED. The register value and all pulses appear in the cycle after the edge that sampled the strobe, and they stay for exactly that cycle.

Top module: `feat_ctl_guard`

## Requirements
- R1: After reset the register reads zero and the fault, flush and reload outputs are low.
- R2: A strobed write whose set bits all lie in the allow mask is committed. The register shows the new data in the cycle after the sampling edge, and the fault output stays low.
- R3: Bits 31 down to 21 and bit 19 are reserved. A write that sets any of them raises the fault output for one cycle and leaves the register unchanged.
- R4: Each gated bit can be set only while its capability input is high: bit 20 (supervisor execution guard) with cap_exec_guard, bit 18 (extended-state enable) with cap_xstate, bit 17 (context-ID enable) with cap_ctx_id, and bit 16 (segment-base access) with cap_seg_base.
- R5: Bits 8 to 15 are outside the default base mask of bits 0 to 7. A write that sets any of them is refused.
- R6: For any one strobe, exactly one of two things happens: the register is updated, or the fault is raised. Never both.
- R7: An accepted write pulses tlb_flush when it changes any of bits 4 (page-size extension), 5 (physical-address extension), 7 (global pages), 17 or 20.
- R8: An accepted write that changes none of those five bits, including a write of the current value, gives no flush.
- R9: pdpt_reload pulses together with a flush only when paging_on is high, the new value has bit 5 set, and long_mode is low.
- R10: A cycle with no write strobe produces no pulse and leaves the register unchanged.
- R11: A write that only clears gated bits is accepted even when their capabilities are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Proposed register value |
| cap_seg_base | input | 1 | Allows bit 16 |
| cap_ctx_id | input | 1 | Allows bit 17 |
| cap_xstate | input | 1 | Allows bit 18 |
| cap_exec_guard | input | 1 | Allows bit 20 |
| paging_on | input | 1 | Paging enabled status |
| long_mode | input | 1 | Long mode active status |
| ctl_q | output | 32 | Current register value |
| wr_fault | output | 1 | Refused-write pulse |
| tlb_flush | output | 1 | TLB flush request pulse |
| pdpt_reload | output | 1 | Pointer-table reload request pulse |

## Verification
The assertions are checked on every cycle. They check that reserved bits never become set and that a fault never coincides with a flush or with a change of the register. They also check that a reload always comes with a flush, that any flush is matched by a real change in a translation bit, and that the execution-guard bit only becomes set when its capability was present at the write. Some behaviour can only be shown by the bench's scenarios. This covers the exact allow mask for each capability combination, that a refusal happens when it should, the no-flush cases for identical or irrelevant writes, and the way paging and long mode select the reload.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
    localparam int CTL_W     = 32;
    localparam int N_CAP     = 4;
    localparam int B_PSE     = 4;
    localparam int B_PAE     = 5;
    localparam int B_PGE     = 7;
    localparam int B_SEGBASE = 16;
    localparam int B_CTXID   = 17;
    localparam int B_XSTATE  = 18;
    localparam int B_EXECG   = 20;

    localparam logic [CTL_W-1:0] FLUSH_MASK =
        (CTL_W'(1) << B_PSE) | (CTL_W'(1) << B_PAE) | (CTL_W'(1) << B_PGE) |
        (CTL_W'(1) << B_CTXID) | (CTL_W'(1) << B_EXECG);

    localparam logic [CTL_W-1:0] RSVD_MASK = 32'hFFE0_0000 | (CTL_W'(1) << 19);

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_TOOK    = 2'd1,
        S_REFUSED = 2'd2
    } wr_state_e;

    // capability vector index -> register bit it unlocks
    function automatic int cap_bit(input int idx);
        case (idx)
            0:       cap_bit = B_SEGBASE;
            1:       cap_bit = B_CTXID;
            2:       cap_bit = B_XSTATE;
            default: cap_bit = B_EXECG;
        endcase
    endfunction
endpackage

// File: rtl/fcg_mask_build.sv
module fcg_mask_build
    import fcg_pkg::*;
#(
    parameter int               W         = CTL_W,
    parameter logic [W-1:0]     LOW_ALLOW = 32'h0000_00FF
) (
    input  logic [N_CAP-1:0] cap_vec,
    output logic [W-1:0]     allow
);
    logic [N_CAP-1:0][W-1:0] part;

    for (genvar g = 0; g < N_CAP; g++) begin : g_cap
        assign part[g] = cap_vec[g] ? ({{(W-1){1'b0}}, 1'b1} << cap_bit(g)) : '0;
    end

    always_comb begin
        allow = LOW_ALLOW;
        for (int i = 0; i < N_CAP; i++) begin
            allow = allow | part[i];
        end
    end
endmodule

// File: rtl/fcg_change_detect.sv
module fcg_change_detect
    import fcg_pkg::*;
#(
    parameter int W = CTL_W
) (
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] new_val,
    input  logic         paging_on,
    input  logic         long_mode,
    output logic         need_flush,
    output logic         need_reload
);
    logic [W-1:0] diff;

    always_comb begin
        diff        = (old_val ^ new_val) & FLUSH_MASK[W-1:0];
        need_flush  = |diff;
        need_reload = need_flush && paging_on && new_val[B_PAE] && !long_mode;
    end
endmodule

// File: rtl/feat_ctl_guard.sv
module feat_ctl_guard
    import fcg_pkg::*;
#(
    parameter logic [CTL_W-1:0] LOW_ALLOW = 32'h0000_00FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             cap_seg_base,
    input  logic             cap_ctx_id,
    input  logic             cap_xstate,
    input  logic             cap_exec_guard,
    input  logic             paging_on,
    input  logic             long_mode,
    output logic [CTL_W-1:0] ctl_q,
    output logic             wr_fault,
    output logic             tlb_flush,
    output logic             pdpt_reload
);
    wr_state_e        state_q, state_d;
    logic [CTL_W-1:0] allow;
    logic             legal;
    logic             need_flush, need_reload;
    logic             flush_q, reload_q;

    fcg_mask_build #(.W(CTL_W), .LOW_ALLOW(LOW_ALLOW)) u_mask (
        .cap_vec ({cap_exec_guard, cap_xstate, cap_ctx_id, cap_seg_base}),
        .allow   (allow)
    );

    fcg_change_detect #(.W(CTL_W)) u_diff (
        .old_val     (ctl_q),
        .new_val     (wr_data),
        .paging_on   (paging_on),
        .long_mode   (long_mode),
        .need_flush  (need_flush),
        .need_reload (need_reload)
    );

    assign legal = ((wr_data & ~allow) == '0);

    // next-state selection
    always_comb begin
        state_d = S_IDLE;
        if (wr_en) begin
            state_d = legal ? S_TOOK : S_REFUSED;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            flush_q  <= 1'b0;
            reload_q <= 1'b0;
        end else begin
            flush_q  <= wr_en && legal && need_flush;
            reload_q <= wr_en && legal && need_reload;
            if (wr_en && legal) begin
                ctl_q <= wr_data;
            end
        end
    end

    // outputs from state
    always_comb begin
        wr_fault    = 1'b0;
        tlb_flush   = 1'b0;
        pdpt_reload = 1'b0;
        unique case (state_q)
            S_IDLE:    ;
            S_TOOK: begin
                tlb_flush   = flush_q;
                pdpt_reload = reload_q;
            end
            S_REFUSED: wr_fault = 1'b1;
            default:   ;
        endcase
    end

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q & RSVD_MASK) == '0);

    // R6
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fault |-> (ctl_q == $past(ctl_q)));

    // R6
    fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_fault && tlb_flush));

    // R9
    reload_needs_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pdpt_reload |-> tlb_flush);

    // R7
    flush_real_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush |-> (((ctl_q ^ $past(ctl_q)) & FLUSH_MASK) != '0));

    // R4
    exec_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[B_EXECG] && !$past(ctl_q[B_EXECG])) |-> $past(cap_exec_guard));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> (!wr_fault && !tlb_flush && ctl_q == $past(ctl_q)));
endmodule

// File: tb/feat_ctl_guard_test.sv
module feat_ctl_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        cap_seg_base = 1'b0, cap_ctx_id = 1'b0, cap_xstate = 1'b0, cap_exec_guard = 1'b0;
    logic        paging_on = 1'b0, long_mode = 1'b0;
    logic [31:0] ctl_q;
    logic        wr_fault, tlb_flush, pdpt_reload;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] model_q = '0;

    always #10 clk = ~clk;

    feat_ctl_guard uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cap_seg_base(cap_seg_base), .cap_ctx_id(cap_ctx_id),
        .cap_xstate(cap_xstate), .cap_exec_guard(cap_exec_guard),
        .paging_on(paging_on), .long_mode(long_mode),
        .ctl_q(ctl_q), .wr_fault(wr_fault), .tlb_flush(tlb_flush),
        .pdpt_reload(pdpt_reload)
    );

    function automatic logic [31:0] exp_allow(input logic s, input logic c,
                                               input logic x, input logic e);
        logic [31:0] m;
        m = 32'h0000_00FF;
        if (s) m[16] = 1'b1;
        if (c) m[17] = 1'b1;
        if (x) m[18] = 1'b1;
        if (e) m[20] = 1'b1;
        return m;
    endfunction

    function automatic logic exp_flush(input logic [31:0] o, input logic [31:0] n);
        logic [31:0] d;
        d = o ^ n;
        return d[4] | d[5] | d[7] | d[17] | d[20];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] d, input string rq_upd,
                            input string rq_flush, input string rq_reload);
        logic ok, fl, rl;
        logic [31:0] nq;
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        ok = ((d & ~exp_allow(cap_seg_base, cap_ctx_id, cap_xstate, cap_exec_guard)) == 0);
        fl = ok && exp_flush(model_q, d);
        rl = fl && paging_on && d[5] && !long_mode;
        nq = ok ? d : model_q;
        @(negedge clk);
        wr_en = 1'b0;
        chk(rq_upd, ctl_q, nq);
        chk("R6", {31'd0, wr_fault}, {31'd0, !ok});
        chk(rq_flush, {31'd0, tlb_flush}, {31'd0, fl});
        chk(rq_reload, {31'd0, pdpt_reload}, {31'd0, rl});
        model_q = nq;
    endtask

    task automatic set_caps(input logic s, input logic c, input logic x, input logic e);
        cap_seg_base = s; cap_ctx_id = c; cap_xstate = x; cap_exec_guard = e;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", ctl_q, 32'h0);
        chk("R1", {29'd0, wr_fault, tlb_flush, pdpt_reload}, 32'h0);
        rst_n = 1'b1;

        set_caps(0, 0, 0, 0);
        do_write(32'h0000_0003, "R2", "R8", "R9");      // low bits, no flush
        do_write(32'h8000_0003, "R3", "R7", "R9");      // bit31 reserved
        do_write(32'h0008_0003, "R3", "R7", "R9");      // bit19 reserved
        do_write(32'h0010_0003, "R4", "R7", "R9");      // exec guard without cap
        do_write(32'h0004_0003, "R4", "R7", "R9");      // xstate without cap
        do_write(32'h0000_1003, "R5", "R7", "R9");      // bit12 outside base
        set_caps(1, 1, 1, 1);
        do_write(32'h0017_0003, "R4", "R7", "R9");      // all gated bits allowed
        do_write(32'h0017_0003, "R2", "R8", "R9");      // identical write
        do_write(32'h0017_0002, "R2", "R8", "R9");      // bit0 only
        set_caps(0, 0, 0, 0);
        do_write(32'h0000_0002, "R11", "R7", "R9");     // clearing gated bits
        paging_on = 1'b1; long_mode = 1'b0;
        do_write(32'h0000_0022, "R2", "R7", "R9");      // PAE on: reload
        do_write(32'h0000_00A2, "R2", "R7", "R9");      // PGE change, PAE kept
        long_mode = 1'b1;
        do_write(32'h0000_0032, "R2", "R7", "R9");      // long mode: no reload
        // R10 idle cycles
        repeat (3) begin
            @(negedge clk);
            chk("R10", ctl_q, model_q);
            chk("R10", {30'd0, wr_fault, tlb_flush}, 32'h0);
        end

        for (int i = 0; i < 400; i++) begin
            logic [31:0] d;
            set_caps($urandom_range(0, 1), $urandom_range(0, 1),
                     $urandom_range(0, 1), $urandom_range(0, 1));
            paging_on = $urandom_range(0, 1);
            long_mode = $urandom_range(0, 1);
            d = $urandom();
            case ($urandom_range(0, 3))
                0: d = d & 32'h0000_00FF;
                1: d = d & 32'h0017_00FF;
                2: d = d & 32'h001F_FFFF;
                default: ;
            endcase
            do_write(d, "R2", "R7", "R9");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule